// File: doc/BRIEF.md
# Paged Byte-Write Controller for a Parallel EEPROM Model

This block is a clocked model of the write side of a byte-wide parallel EEPROM that programs a page at a time. It samples the chip-select, write-enable and output-enable strobes, the address and the data on a system clock. A write strobe is a stretch of cycles where chip-select and write-enable are both low, output-enable is high and the reset pin is high. The strobe must also outlast a short glitch filter. The first accepted strobe freezes the page number. Every accepted strobe records one byte, at the offset taken from the low address bits, into a page buffer.

Each new strobe must start within a load window. Once the strobes have stayed quiet for an idle period, the block runs an internal program cycle of fixed length. At the end of that cycle, the loaded bytes are copied into a behavioural memory array. A busy output pulls low for the whole load-and-program span. Pulling the reset pin low blocks reads and writes, and it cancels a pending or running program cycle. A simple read path returns array contents whenever the part is not busy.

All thresholds are parameters counted in clock cycles.

Top module: `page_eeprom_ctrl`

## Requirements
- R1: A write strobe is recognised only while ceN=0, weN=0, oeN=1 and resN=1. The address is taken when the strobe is accepted, and the data on the last cycle before the strobe ends. A strobe with oeN=0 starts nothing.
- R2: The page number (address bits above the low 6) is frozen by the first accepted strobe. Later strobes in the same load use only address bits 5..0 as the byte offset, so their page bits have no effect.
- R3: A strobe whose start is accepted more than WIN_CYC cycles after the previous accepted start is ignored and its byte is not loaded.
- R4: The program cycle begins after IDLE_CYC cycles with no strobe active after the last byte. It lasts PROG_CYC cycles, and the array changes only at its end.
- R5: Strobes that arrive during the program cycle are ignored.
- R6: busyPullLow is 1 from the cycle after the first accepted strobe until the program cycle ends. It is 0 otherwise (0 models high impedance).
- R7: While resN=0, no strobe is accepted and dataOutEn is 0.
- R8: Driving resN low during a load or program cycle ends it at once, releases busyPullLow, and writes nothing.
- R9: A strobe that lasts GLITCH_CYC cycles or fewer is treated as noise and starts nothing.
- R10: Only bytes loaded in the page are written. The other bytes of that page keep their previous value.
- R11: When the same offset is loaded twice in one page load, the last value wins.
- R12: After rstN, busyPullLow is 0 and every array byte reads 8'hFF.
- R13: With ceN=0, oeN=0, weN=1, resN=1 and not busy, dataOutEn=1 and dataOut equals the array byte at addr. While busy, dataOutEn=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low system reset |
| ceN | input | 1 | Active-low chip select |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| resN | input | 1 | Active-low protect/abort pin |
| addr | input | ADDR_W | Byte address |
| dataIn | input | DATA_W | Write data |
| dataOut | output | DATA_W | Read data (0 when not enabled) |
| dataOutEn | output | 1 | Read data valid / drive enable |
| busyPullLow | output | 1 | 1 = busy line pulled low, 0 = released |

## Verification
Two events can fall in the same cycle: a reset-pin drop and the program-cycle commit, or a late strobe and the idle timeout that starts programming. The bench provokes the first kind by lowering resN partway into the program cycle. It then judges the result at the ports: busy must release and the page must still read 8'hFF. It provokes the second kind by strobing inside the program window and by strobing just past the load window. Each time, the bench reads back the neighbouring offset and expects it to be untouched, while the earlier byte is present.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef struct packed {
    logic capFirst;   // freeze page number, clear valid mask
    logic capOffset;  // record byte offset of an accepted strobe
    logic loadByte;   // store latched data into page buffer
    logic commit;     // copy buffer into array
  } pgw_ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} pgw_state_t;
endpackage

// File: rtl/pgw_strobe.sv
module pgw_strobe #(
  parameter int DATA_W     = 8,
  parameter int GLITCH_CYC = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              resN,
  input  logic [DATA_W-1:0] dataIn,
  output logic              strobeRise,
  output logic              strobeFall,
  output logic              strobeActive,
  output logic [DATA_W-1:0] dataLat
);
  localparam int CNT_W = $clog2(GLITCH_CYC + 2);

  logic             raw;
  logic [CNT_W-1:0] runCnt;

  assign raw        = !ceN && !weN && oeN && resN;
  assign strobeRise = raw && (runCnt == CNT_W'(GLITCH_CYC)) && !strobeActive;
  assign strobeFall = strobeActive && !raw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt       <= '0;
      strobeActive <= 1'b0;
      dataLat      <= '0;
    end else if (!raw) begin
      runCnt       <= '0;
      strobeActive <= 1'b0;
    end else begin
      dataLat <= dataIn;
      if (runCnt < CNT_W'(GLITCH_CYC)) runCnt <= runCnt + 1'b1;
      if (strobeRise) strobeActive <= 1'b1;
    end
  end
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int WIN_CYC  = 7500,
  parameter int IDLE_CYC = 25000,
  parameter int PROG_CYC = 2500000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      resN,
  input  logic      strobeRise,
  input  logic      strobeFall,
  input  logic      strobeActive,
  output pgw_ctrl_t ctrl,
  output logic      busy
);
  localparam int WIN_W  = $clog2(WIN_CYC + 1);
  localparam int IDLE_W = $clog2(IDLE_CYC + 1);
  localparam int PROG_W = $clog2(PROG_CYC + 1);

  pgw_state_t        state, nxt;
  logic [WIN_W-1:0]  winCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic [PROG_W-1:0] progCnt;
  logic              accepted;
  logic              winOpen;

  assign winOpen = winCnt < WIN_W'(WIN_CYC);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    ctrl = '0;
    nxt  = state;
    if (!resN) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (strobeRise) begin
          ctrl.capFirst  = 1'b1;
          ctrl.capOffset = 1'b1;
          nxt            = ST_LOAD;
        end
        ST_LOAD: begin
          if (strobeRise && winOpen) ctrl.capOffset = 1'b1;
          if (strobeFall && accepted) ctrl.loadByte = 1'b1;
          if (!strobeActive && !strobeRise && idleCnt == IDLE_W'(IDLE_CYC - 1))
            nxt = ST_PROG;
        end
        ST_PROG: if (progCnt == PROG_W'(PROG_CYC - 1)) begin
          ctrl.commit = 1'b1;
          nxt         = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      winCnt   <= '0;
      idleCnt  <= '0;
      progCnt  <= '0;
      accepted <= 1'b0;
    end else begin
      state <= nxt;
      if (ctrl.capOffset) winCnt <= '0;
      else if (state == ST_LOAD && winOpen) winCnt <= winCnt + 1'b1;

      if (ctrl.capOffset || ctrl.loadByte) idleCnt <= '0;
      else if (state == ST_LOAD && !strobeActive) idleCnt <= idleCnt + 1'b1;

      if (state != ST_PROG || nxt != ST_PROG) progCnt <= '0;
      else progCnt <= progCnt + 1'b1;

      if (!resN || strobeFall) accepted <= 1'b0;
      else if (ctrl.capOffset) accepted <= 1'b1;
    end
  end
endmodule

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgw_ctrl_t         ctrl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataLat,
  output logic [DATA_W-1:0] arrayRd
);
  localparam int PAGE_SZ = 1 << PAGE_BITS;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PG_W    = ADDR_W - PAGE_BITS;

  logic [PG_W-1:0]      pageReg;
  logic [PAGE_BITS-1:0] offReg;
  logic [PAGE_SZ-1:0]   validMask;
  logic [DATA_W-1:0]    pageBuf [PAGE_SZ];
  logic [DATA_W-1:0]    memArr  [DEPTH];

  assign arrayRd = memArr[addr];

  always_ff @(posedge clk) begin
    if (ctrl.loadByte) pageBuf[offReg] <= dataLat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg   <= '0;
      offReg    <= '0;
      validMask <= '0;
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '1;
    end else begin
      if (ctrl.capFirst) begin
        pageReg   <= addr[ADDR_W-1:PAGE_BITS];
        validMask <= '0;
      end
      if (ctrl.capOffset) offReg <= addr[PAGE_BITS-1:0];
      if (ctrl.loadByte) validMask[offReg] <= 1'b1;
      if (ctrl.commit) begin
        for (int i = 0; i < PAGE_SZ; i++)
          if (validMask[i]) memArr[{pageReg, PAGE_BITS'(i)}] <= pageBuf[i];
      end
    end
  end
endmodule

// File: rtl/page_eeprom_ctrl.sv
module page_eeprom_ctrl
  import pgw_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int PAGE_BITS  = 6,
  parameter int GLITCH_CYC = 5,
  parameter int WIN_CYC    = 7500,
  parameter int IDLE_CYC   = 25000,
  parameter int PROG_CYC   = 2500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              resN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              busyPullLow
);
  pgw_ctrl_t         ctrl;
  logic              strobeRise, strobeFall, strobeActive;
  logic [DATA_W-1:0] dataLat, arrayRd;

  pgw_strobe #(.DATA_W(DATA_W), .GLITCH_CYC(GLITCH_CYC)) u_strobe (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .resN(resN),
    .dataIn(dataIn), .strobeRise(strobeRise), .strobeFall(strobeFall),
    .strobeActive(strobeActive), .dataLat(dataLat)
  );

  pgw_ctrl #(.WIN_CYC(WIN_CYC), .IDLE_CYC(IDLE_CYC), .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .resN(resN), .strobeRise(strobeRise),
    .strobeFall(strobeFall), .strobeActive(strobeActive),
    .ctrl(ctrl), .busy(busyPullLow)
  );

  pgw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .addr(addr),
    .dataLat(dataLat), .arrayRd(arrayRd)
  );

  assign dataOutEn = !ceN && !oeN && weN && resN && !busyPullLow;
  assign dataOut   = dataOutEn ? arrayRd : '0;
endmodule

// File: rtl/page_eeprom_chk.sv
module page_eeprom_chk
  import pgw_pkg::*;
#(
  parameter int GLITCH_CYC = 5
) (
  input logic      clk,
  input logic      rstN,
  input logic      ceN,
  input logic      weN,
  input logic      oeN,
  input logic      resN,
  input logic      busyPullLow,
  input pgw_ctrl_t ctrl
);
  localparam int RUN_W = $clog2(GLITCH_CYC + 2);
  logic [RUN_W-1:0] runLen;
  logic             rawWr;

  assign rawWr = !ceN && !weN && oeN && resN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (!rawWr) runLen <= '0;
    else if (runLen < RUN_W'(GLITCH_CYC)) runLen <= runLen + 1'b1;
  end

  // R1: busy can only start from a real write strobe with oeN high
  p_busy_from_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyPullLow) |-> $past(rawWr));

  // R9: the strobe that started busy outlasted the glitch filter
  p_glitch_filtered_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyPullLow) |-> $past(runLen) >= RUN_W'(GLITCH_CYC));

  // R8: reset pin low while busy releases busy on the next cycle
  p_abort_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!resN && busyPullLow) |=> !busyPullLow);

  // R7: no busy start while the reset pin is low
  p_res_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    !resN |=> !$rose(busyPullLow));

  // R4: control strobes to the datapath never collide
  p_ctrl_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.capOffset, ctrl.loadByte, ctrl.commit}));
endmodule

bind page_eeprom_ctrl page_eeprom_chk #(.GLITCH_CYC(GLITCH_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .resN(resN),
  .busyPullLow(busyPullLow), .ctrl(ctrl)
);

// File: tb/page_eeprom_ctrl_tb.sv
module page_eeprom_ctrl_tb;
  localparam int AW = 10, DW = 8;
  localparam int GL = 2, WIN = 40, IDLE = 60, PROG = 100;

  logic clk = 0, rstN = 0, ceN = 1, weN = 1, oeN = 1, resN = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0, dataOut;
  logic dataOutEn, busyPullLow;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  page_eeprom_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(6), .GLITCH_CYC(GL),
    .WIN_CYC(WIN), .IDLE_CYC(IDLE), .PROG_CYC(PROG)) u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .resN(resN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn),
    .busyPullLow(busyPullLow));

  localparam logic [17:0] VEC [4] = '{
    {10'd0, 8'h5A}, {10'd63, 8'hC3}, {10'd512, 8'h01}, {10'd1023, 8'h80}};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrByte(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int len, input int gap);
    @(negedge clk); addr = a; dataIn = d; ceN = 0; weN = 0;
    repeat (len) @(negedge clk);
    ceN = 1; weN = 1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic rdByte(input logic [AW-1:0] a, output logic [DW-1:0] d,
                        output logic en);
    @(negedge clk); addr = a; ceN = 0; oeN = 0; #1;
    d = dataOut; en = dataOutEn;
    @(negedge clk); ceN = 1; oeN = 1;
  endtask

  task automatic waitIdle(output int cyc);
    cyc = 0;
    while (busyPullLow && cyc < 2000) begin @(negedge clk); cyc++; end
  endtask

  task automatic expRd(input string tag, input logic [AW-1:0] a,
                       input logic [DW-1:0] exp);
    logic [DW-1:0] d; logic en;
    rdByte(a, d, en);
    chk({tag, " en"}, en, 1);
    chk(tag, d, exp);
  endtask

  initial begin
    logic [DW-1:0] d; logic en; int cyc;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R12 busy after reset", busyPullLow, 0);
    expRd("R12 erased", 10'd5, 8'hFF);

    // vector table: single-byte writes, timing and readback
    foreach (VEC[i]) begin
      wrByte(VEC[i][17:8], VEC[i][7:0], 4, 3);
      chk("R6 busy after strobe", busyPullLow, 1);
      rdByte(VEC[i][17:8], d, en);
      chk("R13 no read while busy", en, 0);
      waitIdle(cyc);
      checks++;
      if (cyc < IDLE + PROG - 8 || cyc > IDLE + PROG + 2) begin
        errors++;
        $display("FAIL R4 program span actual=%0d expected=%0d", cyc, IDLE + PROG - 3);
      end
      expRd("R13 readback", VEC[i][17:8], VEC[i][7:0]);
    end

    // R2, R10, R11: multi-byte page, page bits of later strobes ignored
    wrByte(10'd323, 8'h11, 4, 3);
    wrByte(10'd452, 8'h22, 4, 3);
    wrByte(10'd323, 8'h33, 4, 3);
    waitIdle(cyc);
    expRd("R11 last value wins", 10'd323, 8'h33);
    expRd("R2 offset into frozen page", 10'd324, 8'h22);
    expRd("R2 other page untouched", 10'd452, 8'hFF);
    expRd("R10 unloaded byte kept", 10'd325, 8'hFF);

    // R5: strobe during program is ignored
    wrByte(10'd128, 8'h44, 4, 3);
    repeat (IDLE + 10) @(negedge clk);
    chk("R5 in program", busyPullLow, 1);
    wrByte(10'd129, 8'h55, 4, 3);
    waitIdle(cyc);
    expRd("R5 ignored byte", 10'd129, 8'hFF);
    expRd("R5 first byte", 10'd128, 8'h44);

    // R3: late strobe outside load window
    wrByte(10'd192, 8'h66, 4, 3);
    repeat (WIN) @(negedge clk);
    wrByte(10'd193, 8'h77, 4, 3);
    waitIdle(cyc);
    expRd("R3 late byte dropped", 10'd193, 8'hFF);
    expRd("R3 early byte kept", 10'd192, 8'h66);

    // R9: short pulse is noise
    wrByte(10'd900, 8'h12, GL, 3);
    chk("R9 glitch no busy", busyPullLow, 0);
    repeat (IDLE + PROG + 5) @(negedge clk);
    expRd("R9 glitch no write", 10'd900, 8'hFF);

    // R1: oeN low blocks write
    @(negedge clk); oeN = 0;
    wrByte(10'd901, 8'h34, 4, 3);
    oeN = 1;
    chk("R1 oe low no busy", busyPullLow, 0);

    // R7: reset pin low blocks write and read
    @(negedge clk); resN = 0;
    wrByte(10'd902, 8'h56, 4, 3);
    chk("R7 no busy in reset", busyPullLow, 0);
    rdByte(10'd902, d, en);
    chk("R7 no read in reset", en, 0);
    resN = 1;
    expRd("R7 no write in reset", 10'd902, 8'hFF);

    // R8: abort during program
    wrByte(10'd576, 8'h99, 4, 3);
    repeat (IDLE + 20) @(negedge clk);
    chk("R8 busy before abort", busyPullLow, 1);
    resN = 0;
    @(negedge clk);
    chk("R8 busy released", busyPullLow, 0);
    resN = 1;
    repeat (PROG + 5) @(negedge clk);
    expRd("R8 aborted write", 10'd576, 8'hFF);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule